// File: doc/BRIEF.md
# Vectored Interrupt Source Router

This block collects seven level-sensitive interrupt inputs and routes them onto a small set of output interrupt lines. Routing is held in six vector registers, one for each source except that inputs 0 and 1 share vector 0. Each vector stores a destination server number, a priority and an output-line select. Each vector also holds a pending flag, which is computed from the level of its source and from whether that source is masked.

Software reaches the vectors through a simple 64-bit read/write port. Addresses 0 to 5 select a vector. Address 6 is a read-only control word that carries the status of the two shared inputs. Address 7 is a read-only status word that carries the status of the other five inputs.

A vector is masked when its priority is all ones. Masking clears the pending flag but does not block the output line. An output line is high while any vector that selects it has an asserted source. Each vector's effective server number (the stored server with its two link-pointer bits dropped) and its priority are exposed as outputs. No acknowledge or end-of-interrupt exchange exists: the pending flag tracks source levels.

Top module: `irq_source_router`

## Requirements
- R1: After reset every vector v reads back server 0, priority 0xFF, select v and pending 0. All output lines and `err_o` are low.
- R2: A vector word packs the server in bits 55:40, the priority in bits 39:32, the select in bits 31:29 and pending in bit 24. A write stores only the server, priority and select fields, and every other bit reads back as 0.
- R3: For each vector, `srv_o` shows the stored server shifted right by 2 and `prio_o` shows the stored priority.
- R4: Status bits follow the inputs one clock later. Input 0 appears in bit 47 and input 1 in bit 46 of address 6. Inputs 2 to 6 appear in bits 36 down to 32 of address 7, with input 2 at bit 36.
- R5: From the clock after the inputs change, output line k is high exactly while some vector whose select equals k has an asserted source. Masking does not gate the line.
- R6: A vector whose priority is 0xFF never has its pending flag set.
- R7: When a vector's source level changes, its pending flag becomes 1 if the new level is asserted and the vector is unmasked, and becomes 0 otherwise.
- R8: A vector write keeps the current pending flag, except that a new priority of 0xFF clears it. A write alone never sets pending.
- R9: Vector 0 treats input 0 OR input 1 as its level. Its line and its pending flag stay set while either input is still high.
- R10: A vector write whose select is at or above the number of lines (6) is dropped entirely, and `err_o` is high for the one following cycle.
- R11: Writes to addresses 6 and 7 change no state and raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 7 | Level interrupt inputs |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register index |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for `addr_i` (combinational) |
| err_o | output | 1 | Rejected-write flag, one cycle |
| line_o | output | 6 | Output interrupt lines |
| srv_o | output | 84 | Effective server per vector, 14 bits each |
| prio_o | output | 48 | Priority per vector, 8 bits each |

## Verification
Sources are raised one at a time to separate the status-bit mapping from the routing. Two vectors are pointed at the same line to show that the line is an OR of its sources. A masked source that still drives its line separates line behaviour from pending behaviour. The shared pair is raised, overlapped and released in staggered order, so an implementation that follows only one input of the pair fails. Writes to a vector while its level is held, with the priority masked and then unmasked, show that pending changes on level changes and not on writes. An out-of-range select and writes to the status addresses show that dropped writes leave every field intact.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int WORD_W   = 64;
    localparam int SRV_LSB  = 40;
    localparam int SRV_W    = 16;
    localparam int PRI_LSB  = 32;
    localparam int PRI_W    = 8;
    localparam int SEL_LSB  = 29;
    localparam int SEL_W    = 3;
    localparam int PEND_BIT = 24;
    localparam int LINK_W   = 2;
    localparam int EFF_W    = SRV_W - LINK_W;

    // status bit positions
    localparam int SHR_A_BIT = 47;
    localparam int SHR_B_BIT = 46;
    localparam int STAT_TOP  = 36;

    localparam logic [PRI_W-1:0] PRI_MASKED = '1;

    typedef struct packed {
        logic [SRV_W-1:0] srv;
        logic [PRI_W-1:0] pri;
        logic [SEL_W-1:0] sel;
        logic             pend;
    } vec_t;

    function automatic logic is_masked(logic [PRI_W-1:0] p);
        return p == PRI_MASKED;
    endfunction

    function automatic logic [EFF_W-1:0] eff_server(logic [SRV_W-1:0] s);
        return s[SRV_W-1:LINK_W];
    endfunction

    function automatic logic [WORD_W-1:0] vec_to_word(vec_t v);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SRV_LSB +: SRV_W] = v.srv;
        w[PRI_LSB +: PRI_W] = v.pri;
        w[SEL_LSB +: SEL_W] = v.sel;
        w[PEND_BIT]         = v.pend;
        return w;
    endfunction

endpackage

// File: rtl/irq_vec_slot.sv
module irq_vec_slot
    import irq_route_pkg::*;
#(
    parameter int IDX       = 0,
    parameter int NUM_LINES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lvl_q,
    input  logic              lvl_d,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output vec_t              vec_o
);

    vec_t vec_q, vec_n;
    logic masked_n;

    always_comb begin
        vec_n = vec_q;
        if (wr_i) begin
            vec_n.srv = wdata_i[SRV_LSB +: SRV_W];
            vec_n.pri = wdata_i[PRI_LSB +: PRI_W];
            vec_n.sel = wdata_i[SEL_LSB +: SEL_W];
        end
        masked_n = is_masked(vec_n.pri);
        if (lvl_d != lvl_q) begin
            vec_n.pend = lvl_d && !masked_n;
        end else if (wr_i && masked_n) begin
            vec_n.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q.srv  <= '0;
            vec_q.pri  <= PRI_MASKED;
            vec_q.sel  <= SEL_W'(IDX);
            vec_q.pend <= 1'b0;
        end else begin
            vec_q <= vec_n;
        end
    end

    assign vec_o = vec_q;

    p_mask_no_pend_r6: assert property (@(posedge clk) disable iff (rst)
        is_masked(vec_q.pri) |-> !vec_q.pend);

    p_pend_needs_level_r7: assert property (@(posedge clk) disable iff (rst)
        vec_q.pend |-> lvl_q);

    p_sel_in_range_r10: assert property (@(posedge clk) disable iff (rst)
        int'(vec_q.sel) < NUM_LINES);

endmodule

// File: rtl/irq_line_fanout.sv
module irq_line_fanout
    import irq_route_pkg::*;
#(
    parameter int NUM_VEC   = 6,
    parameter int NUM_LINES = 6
) (
    input  logic [NUM_VEC-1:0]            lvl_i,
    input  logic [NUM_VEC-1:0][SEL_W-1:0] sel_i,
    output logic [NUM_LINES-1:0]          line_o
);

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int v = 0; v < NUM_VEC; v++) begin
                if (lvl_i[v] && (sel_i[v] == SEL_W'(l))) hit = 1'b1;
            end
        end
        assign line_o[l] = hit;
    end

endmodule

// File: rtl/irq_source_router.sv
module irq_source_router
    import irq_route_pkg::*;
#(
    parameter int NUM_VEC   = 6,
    parameter int NUM_LINES = 6,
    localparam int NUM_SRC  = NUM_VEC + 1,
    localparam int ADDR_W   = $clog2(NUM_VEC + 2)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0]         src_i,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [WORD_W-1:0]          wdata_i,
    output logic [WORD_W-1:0]          rdata_o,
    output logic                       err_o,
    output logic [NUM_LINES-1:0]       line_o,
    output logic [NUM_VEC*EFF_W-1:0]   srv_o,
    output logic [NUM_VEC*PRI_W-1:0]   prio_o
);

    localparam logic [ADDR_W-1:0] ADR_CTL  = ADDR_W'(NUM_VEC);
    localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(NUM_VEC + 1);

    logic [NUM_SRC-1:0]            stat_q;
    logic [NUM_VEC-1:0]            lvl_q, lvl_d, wr_hit;
    logic [NUM_VEC-1:0][SEL_W-1:0] sel_all;
    vec_t                          vec [NUM_VEC];
    logic                          wr_vec, sel_ok, err_q;

    // live level capture
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= src_i;
    end

    // write decode
    assign wr_vec = wr_en_i && (addr_i < ADR_CTL);
    assign sel_ok = int'(wdata_i[SEL_LSB +: SEL_W]) < NUM_LINES;

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= wr_vec && !sel_ok;
    end
    assign err_o = err_q;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        if (v == 0) begin : g_shared
            assign lvl_q[v] = stat_q[0] | stat_q[1];
            assign lvl_d[v] = src_i[0] | src_i[1];
        end else begin : g_single
            assign lvl_q[v] = stat_q[v+1];
            assign lvl_d[v] = src_i[v+1];
        end

        assign wr_hit[v] = wr_vec && sel_ok && (addr_i == ADDR_W'(v));

        irq_vec_slot #(.IDX(v), .NUM_LINES(NUM_LINES)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .lvl_q   (lvl_q[v]),
            .lvl_d   (lvl_d[v]),
            .wr_i    (wr_hit[v]),
            .wdata_i (wdata_i),
            .vec_o   (vec[v])
        );

        assign sel_all[v]                = vec[v].sel;
        assign srv_o[v*EFF_W +: EFF_W]   = eff_server(vec[v].srv);
        assign prio_o[v*PRI_W +: PRI_W]  = vec[v].pri;
    end

    irq_line_fanout #(.NUM_VEC(NUM_VEC), .NUM_LINES(NUM_LINES)) u_fanout (
        .lvl_i  (lvl_q),
        .sel_i  (sel_all),
        .line_o (line_o)
    );

    // read mux
    always_comb begin
        rdata_o = '1;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (addr_i == ADDR_W'(v)) rdata_o = vec_to_word(vec[v]);
        end
        if (addr_i == ADR_CTL) begin
            rdata_o            = '0;
            rdata_o[SHR_A_BIT] = stat_q[0];
            rdata_o[SHR_B_BIT] = stat_q[1];
        end
        if (addr_i == ADR_STAT) begin
            rdata_o = '0;
            for (int s = 2; s < NUM_SRC; s++) begin
                rdata_o[STAT_TOP - (s - 2)] = stat_q[s];
            end
        end
    end

    p_shared_holds_line_r9: assert property (@(posedge clk) disable iff (rst)
        (stat_q[0] || stat_q[1]) |-> line_o[vec[0].sel]);

    p_reject_keeps_sel_r10: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $stable(sel_all));

endmodule

// File: tb/irq_source_router_tb_top.sv
module irq_source_router_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  src = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        err;
    logic [5:0]  line;
    logic [83:0] srv;
    logic [47:0] prio;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_source_router dut_i (
        .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .line_o(line),
        .srv_o(srv), .prio_o(prio)
    );

    function automatic logic [63:0] vw(logic [15:0] s, logic [7:0] p, logic [2:0] sel, logic pd);
        return {8'h00, s, p, sel, 4'h0, pd, 24'h0};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_src(logic [6:0] s);
        @(negedge clk);
        src = s;
        @(posedge clk); #1;
    endtask

    task automatic rd(logic [2:0] a, output logic [63:0] d);
        @(negedge clk);
        addr = a; #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        for (int v = 0; v < 6; v++) begin
            rd(3'(v), d);
            chk("R1 vector reset", d, vw(16'h0, 8'hFF, 3'(v), 1'b0));
            chk("R1 prio_o reset", 64'(prio[v*8 +: 8]), 64'hFF);
        end
        chk("R1 lines low", 64'(line), 64'h0);
        chk("R1 err low", 64'(err), 64'h0);
        chk("R1 srv_o zero", 64'(srv[63:0]), 64'h0);
    endtask

    task automatic t_fields();
        logic [63:0] d;
        wr(3'd2, 64'hFFFF_FFFF_7FFF_FFFF);
        rd(3'd2, d);
        chk("R2 only fields kept", d, 64'h00FF_FFFF_6000_0000);
        chk("R3 eff server all ones", 64'(srv[2*14 +: 14]), 64'h3FFF);
        wr(3'd2, vw(16'h1234, 8'h10, 3'd2, 1'b1));
        rd(3'd2, d);
        chk("R2 pend bit not writable", d, vw(16'h1234, 8'h10, 3'd2, 1'b0));
        chk("R3 eff server shifted", 64'(srv[2*14 +: 14]), 64'h48D);
        chk("R3 prio out", 64'(prio[2*8 +: 8]), 64'h10);
    endtask

    task automatic t_status();
        logic [63:0] d;
        for (int s = 0; s < 7; s++) begin
            set_src(7'(1 << s));
            rd(3'd6, d);
            chk("R4 ctrl status", d, (s == 0) ? (64'h1 << 47) : (s == 1) ? (64'h1 << 46) : 64'h0);
            rd(3'd7, d);
            chk("R4 irq status", d, (s >= 2) ? (64'h1 << (38 - s)) : 64'h0);
        end
        set_src(7'h0);
    endtask

    task automatic t_line_pend();
        logic [63:0] d;
        wr(3'd3, vw(16'h0, 8'h05, 3'd3, 1'b0));
        set_src(7'h10);
        chk("R5 line follows src4", 64'(line), 64'h08);
        rd(3'd3, d);
        chk("R7 pend set", 64'(d[24]), 64'h1);
        set_src(7'h00);
        chk("R5 line drops", 64'(line), 64'h0);
        rd(3'd3, d);
        chk("R7 pend clears", 64'(d[24]), 64'h0);
        set_src(7'h20);
        chk("R5 masked still drives line", 64'(line), 64'h10);
        rd(3'd4, d);
        chk("R6 masked no pend", 64'(d[24]), 64'h0);
        set_src(7'h00);
        // two vectors onto line 5
        wr(3'd1, vw(16'h0, 8'hFF, 3'd5, 1'b0));
        set_src(7'h04);
        chk("R5 fan-in first", 64'(line), 64'h20);
        set_src(7'h44);
        chk("R5 fan-in both", 64'(line), 64'h20);
        set_src(7'h40);
        chk("R5 fan-in second", 64'(line), 64'h20);
        set_src(7'h00);
        chk("R5 fan-in none", 64'(line), 64'h0);
    endtask

    task automatic t_keep();
        logic [63:0] d;
        set_src(7'h10);
        wr(3'd3, vw(16'h0, 8'h07, 3'd3, 1'b0));
        rd(3'd3, d);
        chk("R8 write keeps pend", d, vw(16'h0, 8'h07, 3'd3, 1'b1));
        wr(3'd3, vw(16'h0, 8'hFF, 3'd3, 1'b0));
        rd(3'd3, d);
        chk("R8 mask write clears pend", 64'(d[24]), 64'h0);
        wr(3'd3, vw(16'h0, 8'h07, 3'd3, 1'b0));
        rd(3'd3, d);
        chk("R8 unmask write does not set pend", 64'(d[24]), 64'h0);
        set_src(7'h00);
        set_src(7'h10);
        rd(3'd3, d);
        chk("R7 new edge sets pend", 64'(d[24]), 64'h1);
        set_src(7'h00);
    endtask

    task automatic t_shared();
        logic [63:0] d;
        wr(3'd0, vw(16'h0, 8'h01, 3'd0, 1'b0));
        set_src(7'h01);
        chk("R9 line from src0", 64'(line), 64'h01);
        rd(3'd0, d);
        chk("R9 pend from src0", 64'(d[24]), 64'h1);
        set_src(7'h03);
        chk("R9 line both", 64'(line), 64'h01);
        set_src(7'h02);
        chk("R9 line held by src1", 64'(line), 64'h01);
        rd(3'd0, d);
        chk("R9 pend held by src1", 64'(d[24]), 64'h1);
        set_src(7'h00);
        chk("R9 line released", 64'(line), 64'h0);
        rd(3'd0, d);
        chk("R9 pend released", 64'(d[24]), 64'h0);
        wr(3'd0, vw(16'h0, 8'h01, 3'd5, 1'b0));
        set_src(7'h02);
        chk("R9 shared reroute", 64'(line), 64'h20);
        set_src(7'h00);
    endtask

    task automatic t_reject();
        logic [63:0] d;
        wr(3'd1, vw(16'hABCD, 8'h03, 3'd6, 1'b0));
        chk("R10 err pulse", 64'(err), 64'h1);
        @(posedge clk); #1;
        chk("R10 err one cycle", 64'(err), 64'h0);
        rd(3'd1, d);
        chk("R10 vector unchanged", d, vw(16'h0, 8'hFF, 3'd5, 1'b0));
        wr(3'd4, vw(16'h0010, 8'h02, 3'd7, 1'b0));
        chk("R10 err sel7", 64'(err), 64'h1);
        chk("R10 srv unchanged", 64'(srv[4*14 +: 14]), 64'h0);
    endtask

    task automatic t_ignore();
        logic [63:0] d;
        wr(3'd6, '1);
        chk("R11 no err ctl", 64'(err), 64'h0);
        wr(3'd7, '1);
        chk("R11 no err stat", 64'(err), 64'h0);
        rd(3'd6, d);
        chk("R11 ctl unchanged", d, 64'h0);
        rd(3'd7, d);
        chk("R11 stat unchanged", d, 64'h0);
        set_src(7'h10);
        rd(3'd7, d);
        chk("R11 stat still live", d, 64'h1 << 34);
        rd(3'd3, d);
        chk("R11 vector unchanged", d, vw(16'h0, 8'h07, 3'd3, 1'b1));
        set_src(7'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_fields();
        t_status();
        t_line_pend();
        t_keep();
        t_shared();
        t_reject();
        t_ignore();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule